// File: doc/BRIEF.md
# CPU State Snapshot Ring

The block keeps a short history of processor activity for a debug monitor. When the capture strobe is high on a clock edge, it stores one 64-bit snapshot into a ring of 16 slots. A snapshot holds the 32-bit memory access address, the 16-bit CPU state word and 16 zero bits. The CPU state word carries the internal state byte in its upper half and the byte read from the bus in its lower half. The slot index comes from an internal counter. The counter steps by one after each capture and wraps, so the oldest snapshot is the one replaced.

A small monitor processor reads the history one byte at a time through its 16-bit address bus. The ring answers in the 4 KiB window starting at 0x7000. The low seven address bits select the byte: four bits pick the slot and three bits pick the byte within it. Reads are registered and valid one clock after the address. A hit flag tells the monitor's data mux when the returned byte belongs to the ring.

Top module: `cpu_snap_ring`

## Requirements
- R1: A capture writes all 8 bytes of the slot named by `cap_idx` in the same clock edge in which `cap_stb` is high. The ring has 16 slots.
- R2: `cap_idx` is 0 after reset. It increases by 1 modulo 16 on each capture and holds otherwise, so the 17th capture overwrites slot 0.
- R3: Slot layout, little-endian within the slot. Bytes 0..3 hold `cap_addr` with bits 7:0 in byte 0. Byte 4 holds `cap_state[7:0]`, the bus read byte. Byte 5 holds `cap_state[15:8]`, the internal state byte. Bytes 6 and 7 always read 0.
- R4: Inside the window, `mon_addr[6:3]` selects the slot and `mon_addr[2:0]` selects the byte.
- R5: The window is 0x7000..0x7FFF, where `mon_addr[15:12]` = 4'h7. Bits 11:7 are ignored, so the ring repeats every 128 bytes. Outside the window, `rd_hit` is 0 and `rd_data` is 0.
- R6: Reads have exactly one clock of latency. `rd_data` and `rd_hit` reflect the address presented before the previous rising edge and do not change between edges.
- R7: A read and a capture that address the same slot in the same clock return the slot's previous contents.
- R8: Synchronous active-high reset sets `cap_idx`, `rd_data` and `rd_hit` to 0.
- R9: While `cap_stb` is low, no slot changes, whatever `cap_addr` and `cap_state` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_stb | input | 1 | Capture strobe, one snapshot per high cycle |
| cap_addr | input | 32 | Memory access address to record |
| cap_state | input | 16 | CPU state word: internal state byte in the upper half, bus read byte in the lower half |
| cap_idx | output | 4 | Slot the next capture will fill |
| mon_addr | input | 16 | Monitor processor address |
| rd_data | output | 8 | Registered read byte, 0 when outside the window |
| rd_hit | output | 1 | Registered flag: the previous address was inside the window |

## Verification
The assertions check the behaviour that holds on every cycle:
- the index steps modulo 16 on each capture and holds without a strobe;
- the index, data and hit are 0 after reset;
- an address outside the window gives a zero byte and a low hit flag one clock later;
- a read of byte 6 or 7 of any slot gives 0.

The bench's scenarios are needed for everything that depends on stored contents:
- the packing of address and state bytes;
- overwriting of the oldest slot after wrap;
- the mirror inside the window;
- the old-data result of a collision between a read and a capture;
- a slot left untouched while the strobe is low.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int ACC_ADDR_W = 32;
  localparam int STATE_W    = 16;
  localparam int ENTRY_W    = 64;
  localparam int PAD_W      = ENTRY_W - STATE_W - ACC_ADDR_W;
  localparam int LANES      = ENTRY_W / 8;

  typedef logic [ENTRY_W-1:0] snap_entry_t;

  // Little-endian slot image: address in the low bytes, state above it, pad on top.
  function automatic snap_entry_t pack_snap(input logic [ACC_ADDR_W-1:0] acc,
                                            input logic [STATE_W-1:0]    st);
    return {{PAD_W{1'b0}}, st, acc};
  endfunction
endpackage

// File: rtl/snap_wr_index.sv
module snap_wr_index #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst)
      idx <= '0;
    else if (adv)
      idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/snap_addr_decode.sv
module snap_addr_decode #(
  parameter int             BUS_W       = 16,
  parameter logic [15:0]    WIN_BASE    = 16'h7000,
  parameter int             WIN_LOG2    = 12,
  parameter int             BYTE_ADDR_W = 7
) (
  input  logic [BUS_W-1:0]       bus_addr,
  output logic                   hit,
  output logic [BYTE_ADDR_W-1:0] byte_addr
);
  always_comb begin
    hit       = (bus_addr[BUS_W-1:WIN_LOG2] == WIN_BASE[BUS_W-1:WIN_LOG2]);
    byte_addr = bus_addr[BYTE_ADDR_W-1:0];
  end
endmodule

// File: rtl/snap_ram.sv
module snap_ram #(
  parameter int DEPTH = 16,
  parameter int LANES = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SEL_W = $clog2(LANES),
  localparam int RA_W  = IDX_W + SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IDX_W-1:0]   widx,
  input  logic [LANES*8-1:0] wdata,
  input  logic               rd_en,
  input  logic [RA_W-1:0]    raddr,
  output logic [7:0]         rdata,
  output logic               rvalid
);
  logic [LANES*8-1:0] lane_bus;
  logic [SEL_W-1:0]   sel_q;
  logic               hit_q;
  logic [IDX_W-1:0]   rslot;

  assign rslot = raddr[RA_W-1:SEL_W];

  // One narrow memory per byte lane; each maps onto a simple dual-port RAM.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] q;

    always_ff @(posedge clk) begin
      if (we)
        mem[widx] <= wdata[g*8 +: 8];
    end

    // Read-before-write: the read sees the contents present before this edge.
    always_ff @(posedge clk) begin
      q <= mem[rslot];
    end

    assign lane_bus[g*8 +: 8] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      hit_q <= 1'b0;
    end else begin
      sel_q <= raddr[SEL_W-1:0];
      hit_q <= rd_en;
    end
  end

  assign rdata  = hit_q ? lane_bus[sel_q*8 +: 8] : 8'h00;
  assign rvalid = hit_q;
endmodule

// File: rtl/cpu_snap_ring.sv
module cpu_snap_ring
  import snap_pkg::*;
#(
  parameter int          DEPTH    = 16,
  parameter int          BUS_W    = 16,
  parameter logic [15:0] WIN_BASE = 16'h7000,
  parameter int          WIN_LOG2 = 12,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int RA_W  = IDX_W + $clog2(LANES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cap_stb,
  input  logic [ACC_ADDR_W-1:0] cap_addr,
  input  logic [STATE_W-1:0]    cap_state,
  output logic [IDX_W-1:0]      cap_idx,
  input  logic [BUS_W-1:0]      mon_addr,
  output logic [7:0]            rd_data,
  output logic                  rd_hit
);
  logic            win_hit;
  logic [RA_W-1:0] byte_addr;
  snap_entry_t     wentry;

  assign wentry = pack_snap(cap_addr, cap_state);

  snap_wr_index #(.DEPTH(DEPTH)) u_idx (
    .clk (clk),
    .rst (rst),
    .adv (cap_stb),
    .idx (cap_idx)
  );

  snap_addr_decode #(
    .BUS_W      (BUS_W),
    .WIN_BASE   (WIN_BASE),
    .WIN_LOG2   (WIN_LOG2),
    .BYTE_ADDR_W(RA_W)
  ) u_dec (
    .bus_addr  (mon_addr),
    .hit       (win_hit),
    .byte_addr (byte_addr)
  );

  snap_ram #(.DEPTH(DEPTH), .LANES(LANES)) u_ram (
    .clk    (clk),
    .rst    (rst),
    .we     (cap_stb),
    .widx   (cap_idx),
    .wdata  (wentry),
    .rd_en  (win_hit),
    .raddr  (byte_addr),
    .rdata  (rd_data),
    .rvalid (rd_hit)
  );
endmodule

// File: rtl/snap_ring_chk.sv
module snap_ring_chk #(
  parameter int IDX_W = 4,
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cap_stb,
  input logic [IDX_W-1:0] cap_idx,
  input logic [BUS_W-1:0] mon_addr,
  input logic [7:0]       rd_data,
  input logic             rd_hit
);
  logic in_win;
  assign in_win = (mon_addr[15:12] == 4'h7);

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    cap_stb |=> cap_idx == IDX_W'($past(cap_idx) + 1'b1));

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_stb |=> $stable(cap_idx));

  // R5
  outside_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !in_win |=> (rd_data == 8'h00) && !rd_hit);

  // R3
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_win && mon_addr[2:1] == 2'b11) |=> (rd_data == 8'h00) && rd_hit);

  // R8
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (cap_idx == '0) && (rd_data == 8'h00) && !rd_hit);
endmodule

bind cpu_snap_ring snap_ring_chk #(.IDX_W(IDX_W), .BUS_W(BUS_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cap_stb  (cap_stb),
  .cap_idx  (cap_idx),
  .mon_addr (mon_addr),
  .rd_data  (rd_data),
  .rd_hit   (rd_hit)
);

// File: tb/cpu_snap_ring_tb.sv
module cpu_snap_ring_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // Stimulus vectors: {access address, cpu state}
  localparam logic [47:0] VEC [NVEC] = '{
    {32'h0000A50E, 16'h15EA}, {32'h00008100, 16'h0000}, {32'h0FFF8101, 16'h154C},
    {32'h12345678, 16'h9ABC}, {32'hFFFFFFFF, 16'hFFFF}, {32'h80000001, 16'h7F80}};

  logic        clk = 0, rst = 1, cap_stb = 0;
  logic [31:0] cap_addr = '0;
  logic [15:0] cap_state = '0, mon_addr = '0;
  logic [3:0]  cap_idx;
  logic [7:0]  rd_data;
  logic        rd_hit;

  int checks = 0, fails = 0;
  logic [63:0] model [16];
  logic [3:0]  idx_m = '0;

  cpu_snap_ring u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cap(input logic [31:0] a, input logic [15:0] s);
    @(negedge clk); cap_stb = 1; cap_addr = a; cap_state = s;
    @(negedge clk); cap_stb = 0;
    model[idx_m] = {16'h0000, s, a};
    idx_m = idx_m + 1'b1;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d, output logic h);
    @(negedge clk); mon_addr = a;
    @(negedge clk); d = rd_data; h = rd_hit;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    logic h, h2;
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 idx", 32'(cap_idx), 0);
    chk("R8 data", 32'(rd_data), 0);
    chk("R8 hit", 32'(rd_hit), 0);
    rst = 0;

    // R1 R2 R3 R4: table walk, capture then read back every byte
    for (int v = 0; v < NVEC; v++) begin
      cap(VEC[v][47:16], VEC[v][15:0]);
      chk("R2 idx step", 32'(cap_idx), 32'(idx_m));
    end
    for (int e = 0; e < NVEC; e++) begin
      for (int b = 0; b < 8; b++) begin
        rd(16'h7000 | 16'(e * 8 + b), d, h);
        chk("R3 R4 byte", 32'(d), 32'(model[e][b*8 +: 8]));
        chk("R1 hit", 32'(h), 1);
      end
    end

    // R5: mirror inside window and misses outside it
    rd(16'h7F80 | 16'd11, d, h);
    chk("R5 mirror", 32'(d), 32'(model[1][3*8 +: 8]));
    rd(16'h6FFF, d, h);
    chk("R5 below data", 32'(d), 0);
    chk("R5 below hit", 32'(h), 0);
    rd(16'h8000, d, h);
    chk("R5 above data", 32'(d), 0);
    chk("R5 above hit", 32'(h), 0);

    // R6: output holds until the next edge after an address change
    rd(16'h7000 | 16'd24, d, h);
    @(negedge clk); mon_addr = 16'h7000 | 16'd25;
    #1 chk("R6 hold", 32'(rd_data), 32'(model[3][7:0]));
    @(negedge clk);
    chk("R6 update", 32'(rd_data), 32'(model[3][15:8]));

    // R9: strobe low, inputs wiggle, slot and index unchanged
    @(negedge clk); cap_addr = 32'hDEADBEEF; cap_state = 16'h5A5A;
    repeat (3) @(negedge clk);
    chk("R9 idx", 32'(cap_idx), 32'(idx_m));
    rd(16'h7000 | 16'(idx_m * 8), d, h);
    chk("R9 slot", 32'(d), 32'(model[idx_m][7:0]));

    // R7: read and capture same slot same clock return old data
    @(negedge clk); mon_addr = 16'h7000 | 16'(idx_m * 8 + 4);
    cap_stb = 1; cap_addr = 32'h01020304; cap_state = 16'hC3D4;
    @(negedge clk); cap_stb = 0;
    chk("R7 old", 32'(rd_data), 32'(model[idx_m][39:32]));
    model[idx_m] = {16'h0000, 16'hC3D4, 32'h01020304};
    idx_m = idx_m + 1'b1;
    rd(16'h7000 | 16'((idx_m - 1'b1) * 8 + 4), d, h);
    chk("R7 new", 32'(d), 32'hD4);

    // R2: wrap and overwrite of oldest slot
    while (idx_m != 0) cap(32'h11110000 | 32'(idx_m), 16'h0100);
    chk("R2 wrap", 32'(cap_idx), 0);
    cap(32'hCAFEF00D, 16'hBEEF);
    rd(16'h7000, d, h);
    rd(16'h7005, d2, h2);
    chk("R2 overwrite b0", 32'(d), 32'h0D);
    chk("R3 state hi", 32'(d2), 32'hBE);
    rd(16'h7007, d, h);
    chk("R3 pad", 32'(d), 0);

    // R8: reset mid-run
    @(negedge clk); rst = 1;
    @(negedge clk);
    chk("R8 idx again", 32'(cap_idx), 0);
    chk("R8 hit again", 32'(rd_hit), 0);
    rst = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule